// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst Streaming

This block is a mode-0 SPI slave that turns serial transactions into accesses on a parallel register bus. The bus serves four identical channel register banks. Each transaction opens with a one-byte command, sent most-significant bit first. The command selects read or write, one of four channels and a 5-bit register address. Every further byte, for as long as chip select stays low, is a burst transfer. The address steps after each byte, except when the burst starts at register 0. Register 0 is a streaming port: writes to it push the transmit FIFO and reads from it pop the receive FIFO, so a whole FIFO can be filled or drained in one transaction.

The slave runs on a fast system clock. It resynchronises SCLK, chip select and MOSI and finds the SCLK edges itself. MISO is a data bit with a separate output enable. The enable stays off for the whole of a write. In a read it stays off until the channel bits of the command have been received. Read data is fetched one byte ahead, so the most significant bit of each byte is on MISO before the SCLK rising edge that samples it.

Top module: `spi_regbus_slave`

## Requirements
- R1: Command bit 7 selects the direction (1 = write, 0 = read). Bits 6:5 select the channel (00 = channel 0, 01 = channel 1, 10 = channel 2, 11 = channel 3). Bits 4:0 give the start address. Channel and address are valid on `ch_sel` and `reg_addr` while a strobe is high.
- R2: In a write, each complete data byte gives exactly one `reg_wr` pulse, with that byte on `reg_wdata`.
- R3: When the start address is 0, the address stays at 0 for the whole burst. Each write also pulses `tx_push` and each read also pulses `rx_pop`, in the same cycle as the strobe.
- R4: When the start address is not 0, the address steps by one after each data byte. It wraps from 31 to 1 and never reaches 0 again within the burst.
- R5: In a read, `reg_rd` pulses once after the last command bit and once after each data byte, which is N+1 pulses for N data bytes. Data is shifted out MSB first, and each MSB is on `miso` before the SCLK rise that samples it.
- R6: In a write transaction, `miso_oe` stays low throughout, including all data bytes.
- R7: In a read transaction, `miso_oe` is low during the first four SCLK cycles of the command byte. It is high from the fourth falling edge onward, and `miso` is 0 until read data starts.
- R8: If chip select rises partway through a byte, that byte is dropped and gives no write, push or pop.
- R9: `miso_oe` goes low no later than two system clocks after `cs_n` goes high.
- R10: After reset all strobes and `miso_oe` are low. Strobes last one cycle, and `reg_wr` and `reg_rd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock (idles low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso` |
| ch_sel | output | 2 | Channel of the current access |
| reg_addr | output | 5 | Register address of the current access |
| reg_wdata | output | 8 | Write data |
| reg_wr | output | 1 | Write strobe, one cycle |
| reg_rd | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, sampled in the `reg_rd` cycle |
| tx_push | output | 1 | Transmit FIFO push (write at address 0) |
| rx_pop | output | 1 | Receive FIFO pop (read at address 0) |

## Verification
Two functions can fall in the same cycle: the address step caused by one strobe, and the bus access that the strobe itself makes. Each access must use the old address, and the next access the stepped one. The bench drives seeded random bursts that start at every kind of address, including 0 and addresses near 31, and compares the bank contents, FIFO traffic and serial read data with a reference model. A second overlap is chip select rising in the same byte as a data edge. Directed aborts part-way through a byte check that the strobe count does not change.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } spi_phase_t;

   localparam int unsigned SPI_DW   = 8;
   localparam int unsigned SPI_CH_W = 2;
   localparam int unsigned SPI_AW   = 5;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int unsigned         N       = 3,
   parameter int unsigned         STAGES  = 2,
   parameter logic [N-1:0]        RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_rb_sync: STAGES must be at least 2");
      end
      if (N < 1) begin : g_bad_width
         $error("spi_rb_sync: N must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][N-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rb_addr.sv
module spi_rb_addr #(
   parameter int unsigned AW       = 5,
   parameter int unsigned WRAP_MIN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          step,
   output logic [AW-1:0] addr,
   output logic          fixed
);
   localparam logic [AW-1:0] A_MAX  = {AW{1'b1}};
   localparam logic [AW-1:0] A_WRAP = AW'(WRAP_MIN);

   generate
      if (WRAP_MIN == 0 || WRAP_MIN >= (1 << AW)) begin : g_bad_wrap
         $error("spi_rb_addr: WRAP_MIN must be a nonzero address");
      end
   endgenerate

   logic [AW-1:0] addr_q;
   logic          fixed_q;
   logic [AW-1:0] addr_nx;

   assign addr_nx = (addr_q == A_MAX) ? A_WRAP : addr_q + AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         fixed_q <= 1'b0;
      end else if (clear) begin
         addr_q  <= '0;
         fixed_q <= 1'b0;
      end else if (load) begin
         addr_q  <= load_val;
         fixed_q <= (load_val == '0);
      end else if (step && !fixed_q) begin
         addr_q  <= addr_nx;
      end
   end

   assign addr  = addr_q;
   assign fixed = fixed_q;

   // R4
   nozero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fixed_q && !clear && !load) |=> (addr_q != '0));

   // R3
   fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fixed_q && !clear && !load) |=> (addr_q == '0));
endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
   import spi_rb_pkg::*;
#(
   parameter int unsigned DW   = 8,
   parameter int unsigned CH_W = 2,
   parameter int unsigned AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk_s,
   input  logic            cs_s,
   input  logic            mosi_s,
   input  logic [DW-1:0]   reg_rdata,
   input  logic [AW-1:0]   addr,
   input  logic            fixed,
   output logic            addr_load,
   output logic [AW-1:0]   addr_load_val,
   output logic            addr_step,
   output logic [CH_W-1:0] ch_sel,
   output logic [DW-1:0]   reg_wdata,
   output logic            reg_wr,
   output logic            reg_rd,
   output logic            tx_push,
   output logic            rx_pop,
   output logic            miso_bit,
   output logic            oe_req
);
   localparam int unsigned CNT_W    = $clog2(DW);
   localparam int unsigned OE_AFTER = 1 + CH_W + 1;

   generate
      if (DW != 1 + CH_W + AW) begin : g_bad_layout
         $error("spi_rb_engine: command layout must fill one data word");
      end
      if ((1 << CNT_W) != DW) begin : g_bad_dw
         $error("spi_rb_engine: DW must be a power of two");
      end
   endgenerate

   spi_phase_t      phase;
   logic [CNT_W-1:0] bit_cnt;
   logic [DW-1:0]   shin;
   logic [DW-1:0]   shout;
   logic [DW-1:0]   rbuf;
   logic            load_pend;
   logic            wr_mode;
   logic            oe_q;
   logic            sclk_q;
   logic            wr_q, rd_q, push_q, pop_q;
   logic [CH_W-1:0] ch_q;
   logic [DW-1:0]   wdata_q;

   logic            rise, fall, byte_end;
   logic [DW-1:0]   rx_byte;

   assign rise     = sclk_s & ~sclk_q;
   assign fall     = ~sclk_s & sclk_q;
   assign rx_byte  = {shin[DW-2:0], mosi_s};
   assign byte_end = rise && !cs_s && (bit_cnt == CNT_W'(DW-1));

   assign addr_load     = byte_end && (phase == PH_CMD);
   assign addr_load_val = rx_byte[AW-1:0];
   assign addr_step     = wr_q | rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         bit_cnt   <= '0;
         shin      <= '0;
         shout     <= '0;
         rbuf      <= '0;
         load_pend <= 1'b0;
         wr_mode   <= 1'b0;
         oe_q      <= 1'b0;
         sclk_q    <= 1'b0;
         wr_q      <= 1'b0;
         rd_q      <= 1'b0;
         push_q    <= 1'b0;
         pop_q     <= 1'b0;
         ch_q      <= '0;
         wdata_q   <= '0;
      end else begin
         sclk_q <= sclk_s;
         wr_q   <= 1'b0;
         rd_q   <= 1'b0;
         push_q <= 1'b0;
         pop_q  <= 1'b0;
         if (rd_q) rbuf <= reg_rdata;
         if (cs_s) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            oe_q      <= 1'b0;
            shout     <= '0;
            load_pend <= 1'b0;
         end else begin
            if (rise) begin
               shin    <= rx_byte;
               bit_cnt <= bit_cnt + CNT_W'(1);
               if (phase == PH_CMD && bit_cnt == '0) wr_mode <= mosi_s;
            end
            if (byte_end) begin
               if (phase == PH_CMD) begin
                  phase <= PH_DATA;
                  ch_q  <= rx_byte[AW+CH_W-1:AW];
                  if (!rx_byte[DW-1]) begin
                     rd_q      <= 1'b1;
                     pop_q     <= (rx_byte[AW-1:0] == '0);
                     load_pend <= 1'b1;
                  end
               end else if (wr_mode) begin
                  wr_q    <= 1'b1;
                  wdata_q <= rx_byte;
                  push_q  <= fixed;
               end else begin
                  rd_q      <= 1'b1;
                  pop_q     <= fixed;
                  load_pend <= 1'b1;
               end
            end
            if (fall && phase == PH_CMD && bit_cnt == CNT_W'(OE_AFTER) && !wr_mode)
               oe_q <= 1'b1;
            if (fall && phase == PH_DATA && !wr_mode) begin
               if (load_pend) begin
                  shout     <= rbuf;
                  load_pend <= 1'b0;
               end else begin
                  shout <= {shout[DW-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign ch_sel    = ch_q;
   assign reg_wdata = wdata_q;
   assign reg_wr    = wr_q;
   assign reg_rd    = rd_q;
   assign tx_push   = push_q;
   assign rx_pop    = pop_q;
   assign miso_bit  = shout[DW-1];
   assign oe_req    = oe_q;

   // R10
   no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_q && rd_q));

   // R10
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q);

   // R3
   push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_q |-> (wr_q && addr == '0));

   // R3
   pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_q |-> (rd_q && addr == '0));

   // R6
   wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DATA && wr_mode) |-> !oe_q);

   // R8
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !(wr_q || rd_q));
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
   import spi_rb_pkg::*;
#(
   parameter int unsigned DW          = SPI_DW,
   parameter int unsigned CH_W        = SPI_CH_W,
   parameter int unsigned AW          = SPI_AW,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sclk,
   input  logic            cs_n,
   input  logic            mosi,
   output logic            miso,
   output logic            miso_oe,
   output logic [CH_W-1:0] ch_sel,
   output logic [AW-1:0]   reg_addr,
   output logic [DW-1:0]   reg_wdata,
   output logic            reg_wr,
   output logic            reg_rd,
   input  logic [DW-1:0]   reg_rdata,
   output logic            tx_push,
   output logic            rx_pop
);
   logic [2:0]    pins_s;
   logic          addr_load, addr_step, addr_fixed, oe_req, miso_bit;
   logic [AW-1:0] addr_load_val, addr_q;

   spi_rb_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({sclk, cs_n, mosi}),
      .q    (pins_s)
   );

   spi_rb_addr #(.AW(AW), .WRAP_MIN(1)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (pins_s[1]),
      .load    (addr_load),
      .load_val(addr_load_val),
      .step    (addr_step),
      .addr    (addr_q),
      .fixed   (addr_fixed)
   );

   spi_rb_engine #(.DW(DW), .CH_W(CH_W), .AW(AW)) u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .sclk_s       (pins_s[2]),
      .cs_s         (pins_s[1]),
      .mosi_s       (pins_s[0]),
      .reg_rdata    (reg_rdata),
      .addr         (addr_q),
      .fixed        (addr_fixed),
      .addr_load    (addr_load),
      .addr_load_val(addr_load_val),
      .addr_step    (addr_step),
      .ch_sel       (ch_sel),
      .reg_wdata    (reg_wdata),
      .reg_wr       (reg_wr),
      .reg_rd       (reg_rd),
      .tx_push      (tx_push),
      .rx_pop       (rx_pop),
      .miso_bit     (miso_bit),
      .oe_req       (oe_req)
   );

   assign reg_addr = addr_q;
   // The raw select gates the enable so the pin releases without synchronizer delay.
   assign miso_oe  = oe_req & ~cs_n;
   assign miso     = miso_oe & miso_bit;

   // R9
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !miso_oe);
endmodule

// File: tb/sim_spi_regbus_slave.sv
module sim_spi_regbus_slave;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       mosi = 1'b0;
   logic       miso, miso_oe;
   logic [1:0] ch_sel;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic       reg_wr, reg_rd, tx_push, rx_pop;

   always #10 clk = ~clk;

   spi_regbus_slave u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_oe(miso_oe), .ch_sel(ch_sel), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_rdata(reg_rdata), .tx_push(tx_push), .rx_pop(rx_pop)
   );

   int errors = 0;
   int checks = 0;

   function automatic logic [7:0] init_val(int c, int a);
      return 8'((c * 53 + a * 7 + 3) & 255);
   endfunction
   function automatic logic [7:0] rx_val(int c, int i);
      return 8'((c * 37 + i * 13 + 5) & 255);
   endfunction
   function automatic int nxt(int a);
      if (a == 0) return 0;
      return (a == 31) ? 1 : a + 1;
   endfunction

   // bank model
   logic [7:0] mem [4][32];
   logic [7:0] txf [4][512];
   int         tx_cnt [4];
   int         rx_head [4];
   int         wr_cnt, rd_cnt, clash_cnt, bad_push;

   always_comb begin
      if (reg_addr == 5'd0) reg_rdata = rx_val(int'(ch_sel), rx_head[ch_sel]);
      else                  reg_rdata = mem[ch_sel][reg_addr];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 4; c++) begin
            for (int a = 0; a < 32; a++) mem[c][a] <= init_val(c, a);
            tx_cnt[c]  <= 0;
            rx_head[c] <= 0;
         end
         wr_cnt <= 0; rd_cnt <= 0; clash_cnt <= 0; bad_push <= 0;
      end else begin
         if (reg_wr) begin
            wr_cnt <= wr_cnt + 1;
            if (tx_push) begin
               txf[ch_sel][tx_cnt[ch_sel] & 511] <= reg_wdata;
               tx_cnt[ch_sel] <= tx_cnt[ch_sel] + 1;
            end else begin
               mem[ch_sel][reg_addr] <= reg_wdata;
            end
         end
         if (reg_rd) rd_cnt <= rd_cnt + 1;
         if (rx_pop) rx_head[ch_sel] <= rx_head[ch_sel] + 1;
         if (reg_wr && reg_rd) clash_cnt <= clash_cnt + 1;
         if ((tx_push && !reg_wr) || (rx_pop && !reg_rd)) bad_push <= bad_push + 1;
      end
   end

   // expected model
   logic [7:0] exp_mem [4][32];
   logic [7:0] exp_tx  [4][512];
   int         exp_tx_cnt [4];
   int         exp_rx [4];
   logic [7:0] wbuf [64];
   logic [7:0] rbuf [64];
   int         txn_fail;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         txn_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_bit(input bit b, input bit wr, input int idx, output bit got);
      mosi = b;
      wait_clk(HALF);
      got = miso;
      if (idx >= 0) begin
         if (idx < 4) chk(!miso_oe, "R7 hiz first cmd cycles", int'(miso_oe), 0);
         else if (!wr) chk(miso_oe && !miso, "R7 drive zero", int'({miso_oe, miso}), 2);
         else chk(!miso_oe, "R6 cmd hiz", int'(miso_oe), 0);
      end else if (wr) begin
         chk(!miso_oe, "R6 data hiz", int'(miso_oe), 0);
      end
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
   endtask

   task automatic spi_txn(input bit wr, input int ch, input int addr, input int n,
                          input bit abort_mid);
      logic [7:0] cmd;
      bit         g;
      int         wr0, rd0, a, p;
      cmd = {wr, 2'(ch), 5'(addr)};
      wr0 = wr_cnt; rd0 = rd_cnt;
      cs_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < 8; i++) spi_bit(cmd[7-i], wr, i, g);
      for (int b = 0; b < n; b++) begin
         logic [7:0] rv;
         for (int i = 0; i < 8; i++) begin
            spi_bit(wbuf[b][7-i], wr, -1, g);
            rv[7-i] = g;
         end
         rbuf[b] = rv;
      end
      if (abort_mid) for (int i = 0; i < 4; i++) spi_bit(1'b1, wr, -1, g);
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(2);
      chk(!miso_oe, "R9 release", int'(miso_oe), 0);
      wait_clk(HALF);
      a = addr;
      if (wr) begin
         for (int b = 0; b < n; b++) begin
            if (a == 0) begin
               exp_tx[ch][exp_tx_cnt[ch] & 511] = wbuf[b];
               exp_tx_cnt[ch]++;
            end else exp_mem[ch][a] = wbuf[b];
            a = nxt(a);
         end
         chk(wr_cnt - wr0 == n, "R2/R8 write strobe count", wr_cnt - wr0, n);
         p = 0;
         for (int c = 0; c < 4; c++)
            for (int x = 0; x < 32; x++) if (mem[c][x] != exp_mem[c][x]) p++;
         chk(p == 0, "R1/R2/R4 bank contents", p, 0);
         chk(tx_cnt[ch] == exp_tx_cnt[ch], "R3 push count", tx_cnt[ch], exp_tx_cnt[ch]);
         p = 0;
         for (int x = 0; x < exp_tx_cnt[ch] && x < 512; x++) if (txf[ch][x] != exp_tx[ch][x]) p++;
         chk(p == 0, "R3 pushed data", p, 0);
      end else begin
         for (int b = 0; b < n; b++) begin
            logic [7:0] e;
            if (a == 0) begin e = rx_val(ch, exp_rx[ch]); exp_rx[ch]++; end
            else e = exp_mem[ch][a];
            chk(rbuf[b] == e, "R5 read byte", int'(rbuf[b]), int'(e));
            a = nxt(a);
         end
         if (addr == 0) exp_rx[ch]++;
         chk(rd_cnt - rd0 == n + 1, "R5 read strobe count", rd_cnt - rd0, n + 1);
         chk(rx_head[ch] == exp_rx[ch], "R3 pop count", rx_head[ch], exp_rx[ch]);
      end
   endtask

   task automatic fill_wbuf(input int n);
      for (int b = 0; b < n; b++) wbuf[b] = 8'($urandom);
   endtask

   bit done = 1'b0;

   initial begin
      void'($urandom(32'd4711));
      for (int c = 0; c < 4; c++) begin
         for (int a = 0; a < 32; a++) exp_mem[c][a] = init_val(c, a);
         exp_tx_cnt[c] = 0;
         exp_rx[c] = 0;
      end
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(3);
      // R10 reset state
      chk(!miso_oe && !reg_wr && !reg_rd && !tx_push && !rx_pop, "R10 reset state",
          int'({miso_oe, reg_wr, reg_rd, tx_push, rx_pop}), 0);
      // directed: wrap 30,31,1,2 (R4)
      fill_wbuf(4); spi_txn(1'b1, 2, 30, 4, 1'b0);
      // read across wrap (R4, R5)
      spi_txn(1'b0, 2, 31, 3, 1'b0);
      // FIFO stream write and read at address 0 (R3)
      fill_wbuf(6); spi_txn(1'b1, 1, 0, 6, 1'b0);
      spi_txn(1'b0, 3, 0, 5, 1'b0);
      // abort mid byte (R8)
      fill_wbuf(2); spi_txn(1'b1, 0, 5, 2, 1'b1);
      fill_wbuf(1); spi_txn(1'b1, 0, 0, 1, 1'b1);
      // channel select each value (R1)
      for (int c = 0; c < 4; c++) begin
         fill_wbuf(1); spi_txn(1'b1, c, 9, 1, 1'b0);
         spi_txn(1'b0, c, 9, 1, 1'b0);
      end
      // random mix
      for (int t = 0; t < 30; t++) begin
         bit wr;
         int ch, ad, n;
         wr = 1'($urandom);
         ch = int'($urandom_range(3, 0));
         ad = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(31, 0));
         n  = int'($urandom_range(8, 1));
         fill_wbuf(n);
         spi_txn(wr, ch, ad, n, 1'b0);
      end
      chk(clash_cnt == 0, "R10 no wr/rd overlap", clash_cnt, 0);
      chk(bad_push == 0, "R3 push/pop only with strobe", bad_push, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule